// File: doc/BRIEF.md
# Half-Bridge Gate Sequencer with Dead Time and Switch-Node Check

This block produces the high-side (HO) and low-side (LO) gate commands for a half-bridge. A switching cycle has four slots: a dead slot, the LO conduction slot, a second dead slot, and the HO conduction slot. Each conduction slot lasts half the programmed period minus the dead time, so the two sides run at equal duty. While the block is disabled (supply lockout or fault), HO is held low and the LO driver is released to high impedance through a separate output-enable.

A bootstrapped high-side supply is not valid at first start. Until its ready flag goes true, only LO switches and the HO slot runs empty, keeping the cycle timing unchanged. A switch-node comparator bit is sampled at the clock edge where LO turns on. If the preceding HO turn-off armed the check, and the node is still high at that edge, the bridge is hard switching. A one-clock non-ZVS pulse then flags the cycle, so an outer loop can raise the frequency.

Top module: `hb_gate_seq`

## Requirements
- R1: While rst_ni is low, and from the first clock edge that samples en_i low, ho_o, lo_o, lo_oe_o, lo_rise_o and nonzvs_o are all 0.
- R2: When enabled, each cycle runs LO on, dead, HO on, dead. With H = floor(period_i / 2), each conduction slot lasts H - DT clocks, and the cycle lasts 2*H clocks.
- R3: Every transition between the two sides leaves both outputs low for exactly DT clocks in steady operation, and ho_o and lo_o are never high together.
- R4: If floor(period_i / 2) <= DT, each conduction slot is clamped to 1 clock. The dead slots stay DT clocks.
- R5: period_i is taken only at the end of an HO slot (cycle boundary) or while disabled. A change during a cycle does not alter the slots of that cycle.
- R6: HO goes high in an HO slot only if hs_ready_i was 1 at the edge that starts the slot. Otherwise the slot stays empty for its full length, and LO keeps its timing.
- R7: lo_rise_o is 1 for exactly the first clock of every LO conduction slot.
- R8: nonzvs_o is 1 for one clock, coinciding with lo_rise_o, when three conditions hold. An HO pulse ended since the previous LO turn-on, and at the LO turn-on edge both chk_en_i = 1 and sw_high_i = 1 (switch node above threshold).
- R9: nonzvs_o stays 0 at the first LO turn-on after enable, at an LO turn-on that follows an empty HO slot, and whenever chk_en_i = 0.
- R10: lo_oe_o goes to 1 at the first edge that samples en_i high. The first LO turn-on follows at the DT-th such edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low means lockout or fault |
| period_i | input | PW | Switching period in clocks |
| hs_ready_i | input | 1 | High-side supply valid |
| sw_high_i | input | 1 | Sampled comparator: switch node above threshold |
| chk_en_i | input | 1 | Enables the non-ZVS check |
| ho_o | output | 1 | High-side gate command |
| lo_o | output | 1 | Low-side gate command |
| lo_oe_o | output | 1 | Low-side driver enable; 0 releases LO to high impedance |
| lo_rise_o | output | 1 | Strobe on the first clock of each LO slot |
| nonzvs_o | output | 1 | Hard-switching flag at LO turn-on |

## Verification
The default of 100 dead clocks would make every cycle several hundred clocks long. The bench therefore builds the block with DT = 4 and a 10-bit period word. This makes slot lengths short enough to count edge by edge, and it brings the clamp boundary (periods of 8 and 12) and odd periods within a few clocks. The short cycle also allows many cycles to be observed, covering start-up without HO, mid-run supply loss and a period change during an HO slot.

// File: rtl/hb_seq_pkg.sv
package hb_seq_pkg;
  typedef enum logic [1:0] {
    PH_DEAD_LO = 2'd0,
    PH_LO      = 2'd1,
    PH_DEAD_HO = 2'd2,
    PH_HO      = 2'd3
  } phase_e;
endpackage

// File: rtl/hb_on_len.sv
module hb_on_len #(
  parameter int PW = 16,
  parameter int DT = 100
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          load_i,
  input  logic [PW-1:0] period_i,
  output logic [PW-1:0] on_len_o
);
  localparam logic [PW-1:0] DtW = PW'(DT);

  logic [PW-1:0] half;
  logic [PW-1:0] on_d;
  logic [PW-1:0] on_q;

  assign half = period_i >> 1;
  // clamp: conduction slot never shorter than one clock
  assign on_d = (half > DtW) ? half - DtW : PW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                on_q <= PW'(1);
    else if (!en_i || load_i)   on_q <= on_d;
  end

  assign on_len_o = on_q;
endmodule

// File: rtl/hb_phase_timer.sv
module hb_phase_timer
  import hb_seq_pkg::*;
#(
  parameter int PW = 16,
  parameter int DT = 100
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [PW-1:0] on_len_i,
  output phase_e        phase_o,
  output logic          lo_start_o,
  output logic          ho_start_o,
  output logic          wrap_o
);
  localparam logic [PW-1:0] DtW = PW'(DT);

  phase_e        ph_q;
  logic [PW-1:0] cnt_q;
  logic [PW-1:0] lim;
  logic          last;

  assign lim  = (ph_q == PH_LO || ph_q == PH_HO) ? on_len_i - PW'(1) : DtW - PW'(1);
  assign last = (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_DEAD_LO;
      cnt_q <= '0;
    end else if (!en_i) begin
      ph_q  <= PH_DEAD_LO;
      cnt_q <= '0;
    end else if (last) begin
      ph_q  <= phase_e'(ph_q + 2'd1);
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + PW'(1);
    end
  end

  assign phase_o    = ph_q;
  assign lo_start_o = en_i && last && (ph_q == PH_DEAD_LO);
  assign ho_start_o = en_i && last && (ph_q == PH_DEAD_HO);
  assign wrap_o     = en_i && last && (ph_q == PH_HO);
endmodule

// File: rtl/hb_zvs_mon.sv
module hb_zvs_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic ho_off_i,
  input  logic lo_start_i,
  input  logic chk_en_i,
  input  logic sw_high_i,
  output logic nonzvs_o
);
  logic armed_q;
  logic flag_q;

  // armed by an HO turn-off, consumed by the next LO turn-on
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          armed_q <= 1'b0;
    else if (!en_i)       armed_q <= 1'b0;
    else if (ho_off_i)    armed_q <= 1'b1;
    else if (lo_start_i)  armed_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= en_i && lo_start_i && armed_q && chk_en_i && sw_high_i;
  end

  assign nonzvs_o = flag_q;
endmodule

// File: rtl/hb_gate_seq.sv
module hb_gate_seq
  import hb_seq_pkg::*;
#(
  parameter int PW = 16,
  parameter int DT = 100
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [PW-1:0] period_i,
  input  logic          hs_ready_i,
  input  logic          sw_high_i,
  input  logic          chk_en_i,
  output logic          ho_o,
  output logic          lo_o,
  output logic          lo_oe_o,
  output logic          lo_rise_o,
  output logic          nonzvs_o
);
  logic [PW-1:0] on_len;
  phase_e        phase;
  logic          lo_start, ho_start, wrap;
  logic          ho_en_q, oe_q, rise_q;

  hb_on_len #(.PW(PW), .DT(DT)) on_len_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .load_i   (wrap),
    .period_i (period_i),
    .on_len_o (on_len)
  );

  hb_phase_timer #(.PW(PW), .DT(DT)) timer_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .on_len_i   (on_len),
    .phase_o    (phase),
    .lo_start_o (lo_start),
    .ho_start_o (ho_start),
    .wrap_o     (wrap)
  );

  hb_zvs_mon zvs_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .ho_off_i   (wrap && ho_en_q),
    .lo_start_i (lo_start),
    .chk_en_i   (chk_en_i),
    .sw_high_i  (sw_high_i),
    .nonzvs_o   (nonzvs_o)
  );

  // HO permission decided once per slot: whole pulse or none
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ho_en_q <= 1'b0;
    else if (!en_i)     ho_en_q <= 1'b0;
    else if (ho_start)  ho_en_q <= hs_ready_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q   <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      oe_q   <= en_i;
      rise_q <= lo_start;
    end
  end

  assign lo_o      = (phase == PH_LO);
  assign ho_o      = (phase == PH_HO) && ho_en_q;
  assign lo_oe_o   = oe_q;
  assign lo_rise_o = rise_q;
endmodule

// File: rtl/hb_gate_seq_chk.sv
module hb_gate_seq_chk #(
  parameter int DT = 100
) (
  input logic clk_i,
  input logic rst_ni,
  input logic chk_en_i,
  input logic ho_o,
  input logic lo_o,
  input logic lo_oe_o,
  input logic lo_rise_o,
  input logic nonzvs_o
);
  localparam int GW = 16;
  localparam logic [GW-1:0] GMax = '1;

  logic [GW-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            gap_q <= '0;
    else if (ho_o || lo_o)  gap_q <= '0;
    else if (gap_q != GMax) gap_q <= gap_q + GW'(1);
  end

  // R3
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ho_o && lo_o));
  // R3
  ho_dead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ho_o) |-> (gap_q >= GW'(DT)));
  // R3
  lo_dead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lo_o) |-> (gap_q >= GW'(DT)));
  // R1
  released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lo_oe_o |-> (!ho_o && !lo_o));
  // R7
  rise_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_rise_o |-> (lo_o && !$past(lo_o)));
  // R8
  nonzvs_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nonzvs_o |-> (lo_rise_o && $past(chk_en_i)));
  // R8
  nonzvs_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nonzvs_o |=> !nonzvs_o);
endmodule

bind hb_gate_seq hb_gate_seq_chk #(.DT(DT)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .chk_en_i  (chk_en_i),
  .ho_o      (ho_o),
  .lo_o      (lo_o),
  .lo_oe_o   (lo_oe_o),
  .lo_rise_o (lo_rise_o),
  .nonzvs_o  (nonzvs_o)
);

// File: tb/hb_gate_seq_tb_top.sv
`timescale 1ns/1ps
module hb_gate_seq_tb_top;
  localparam int PW = 10;
  localparam int DT = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          en_i = 1'b0;
  logic [PW-1:0] period_i = PW'(40);
  logic          hs_ready_i = 1'b0;
  logic          sw_high_i = 1'b0;
  logic          chk_en_i = 1'b0;
  logic          ho_o, lo_o, lo_oe_o, lo_rise_o, nonzvs_o;

  int total = 0;
  int bad = 0;

  always #10 clk_i = ~clk_i;

  hb_gate_seq #(.PW(PW), .DT(DT)) dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .period_i   (period_i),
    .hs_ready_i (hs_ready_i),
    .sw_high_i  (sw_high_i),
    .chk_en_i   (chk_en_i),
    .ho_o       (ho_o),
    .lo_o       (lo_o),
    .lo_oe_o    (lo_oe_o),
    .lo_rise_o  (lo_rise_o),
    .nonzvs_o   (nonzvs_o)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // measure next full cycle starting at a fresh LO rise; ends on the following rise
  task automatic grab(output int lo_on, output int gap1, output int ho_on, output int gap2);
    @(negedge clk_i);
    while (lo_o) @(negedge clk_i);
    while (!lo_o) @(negedge clk_i);
    lo_on = 0; while (lo_o) begin lo_on++; @(negedge clk_i); end
    gap1 = 0;  while (!lo_o && !ho_o) begin gap1++; @(negedge clk_i); end
    ho_on = 0; while (ho_o) begin ho_on++; @(negedge clk_i); end
    gap2 = 0;  while (!lo_o && !ho_o) begin gap2++; @(negedge clk_i); end
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk("R1 reset ho", int'(ho_o), 0);
    chk("R1 reset lo", int'(lo_o), 0);
    chk("R1 reset oe", int'(lo_oe_o), 0);
    chk("R1 reset strobes", int'(lo_rise_o | nonzvs_o), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R1 idle oe", int'(lo_oe_o), 0);
  endtask

  task automatic t_start();
    int n, a, b, c, d;
    period_i = PW'(40); hs_ready_i = 1'b0; chk_en_i = 1'b1; sw_high_i = 1'b1;
    en_i = 1'b1;
    n = 0;
    @(negedge clk_i); n++;
    chk("R10 oe after first edge", int'(lo_oe_o), 1);
    while (!lo_o) begin @(negedge clk_i); n++; end
    chk("R10 first LO edge count", n, DT);
    chk("R7 strobe at first rise", int'(lo_rise_o), 1);
    chk("R9 no flag at first rise", int'(nonzvs_o), 0);
    grab(a, b, c, d);
    chk("R2 lo on, startup", a, 16);
    chk("R6 empty HO slot gap", b, 24);
    chk("R6 no HO before ready", c, 0);
    chk("R9 no flag after empty slot", int'(nonzvs_o), 0);
  endtask

  task automatic t_ready_nonzvs();
    int a, b, c, d;
    hs_ready_i = 1'b1;
    grab(a, b, c, d);
    chk("R2 lo on", a, 16);
    chk("R3 dead before HO", b, DT);
    chk("R2 ho on", c, 16);
    chk("R3 dead before LO", d, DT);
    chk("R8 flag at rise", int'(nonzvs_o), 1);
    chk("R7 strobe at rise", int'(lo_rise_o), 1);
    @(negedge clk_i);
    chk("R8 flag one clock", int'(nonzvs_o), 0);
    chk("R7 strobe one clock", int'(lo_rise_o), 0);
    chk_en_i = 1'b0;
    grab(a, b, c, d);
    chk("R9 no flag with check off", int'(nonzvs_o), 0);
    chk_en_i = 1'b1; sw_high_i = 1'b0;
    grab(a, b, c, d);
    chk("R8 no flag with node low", int'(nonzvs_o), 0);
  endtask

  task automatic t_supply_drop();
    int a, b, c, d;
    sw_high_i = 1'b1;
    @(negedge clk_i);
    while (!lo_o) @(negedge clk_i);
    hs_ready_i = 1'b0;
    grab(a, b, c, d);
    chk("R6 HO slot empty after drop", c, 0);
    chk("R6 LO timing kept", a + b, 40);
    chk("R9 no flag after empty slot", int'(nonzvs_o), 0);
    hs_ready_i = 1'b1;
    grab(a, b, c, d);
    chk("R6 HO back", c, 16);
  endtask

  task automatic t_period_change();
    int n, a, b, c, d;
    @(negedge clk_i);
    while (!ho_o) @(negedge clk_i);
    period_i = PW'(61);
    n = 0;
    while (ho_o) begin n++; @(negedge clk_i); end
    chk("R5 current HO keeps old length", n, 16);
    grab(a, b, c, d);
    chk("R5 new lo on (odd period)", a, 26);
    chk("R5 new ho on", c, 26);
    chk("R2 cycle length", a + b + c + d, 60);
  endtask

  task automatic t_clamp(int per, int exp_on, string tag);
    int a, b, c, d;
    period_i = PW'(per);
    grab(a, b, c, d);
    grab(a, b, c, d);
    chk({tag, " lo on"}, a, exp_on);
    chk({tag, " ho on"}, c, exp_on);
    chk("R3 dead kept", b + d, 2 * DT);
  endtask

  task automatic t_disable();
    @(negedge clk_i);
    while (!ho_o) @(negedge clk_i);
    en_i = 1'b0;
    @(negedge clk_i);
    chk("R1 ho off at disable", int'(ho_o), 0);
    chk("R1 lo off at disable", int'(lo_o), 0);
    chk("R1 oe off at disable", int'(lo_oe_o), 0);
    repeat (60) @(negedge clk_i);
    chk("R1 stays quiet", int'(ho_o | lo_o | lo_oe_o | nonzvs_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_start();
    t_ready_nonzvs();
    t_supply_drop();
    t_period_change();
    t_clamp(12, 2, "R4 boundary above clamp");
    t_clamp(8, 1, "R4 clamp at limit");
    t_clamp(0, 1, "R4 clamp zero");
    t_disable();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule